// File: doc/BRIEF.md
# Real-Time Clock with Alarm

This block keeps wall-clock time from a 32.768 kHz sub-clock. The sub-clock reaches it as a one-cycle enable strobe, `sub_tick`, already synchronous to the system clock. A binary prescaler turns these strobes into a one-second tick. That tick drives a chain of counters for seconds, minutes, hours and a 16-bit day count.

Two interrupt sources are provided:
- A periodic interrupt that can be set to fire every second, every minute or every day.
- An alarm interrupt that fires when the running time steps into a programmed hour and minute.

Both raise sticky flags, and software clears a flag by writing 1 to it.

Software reaches the block through a small synchronous register port. Reads return data one cycle after the request. A read of the seconds register freezes a copy of the minutes, hours and days, so a multi-register read of the time is self-consistent. Writing any time field restarts the prescaler, so the second that follows is a full one.

Top module: `rtc_alarm_top`

## Requirements
- R1: After reset every time field, both alarm fields, the control register and both flags read as zero, and both interrupt outputs are low.
- R2: The seconds count advances by one on every 2^PRE_W-th `sub_tick` pulse. Cycles with `sub_tick` low do not advance the prescaler.
- R3: The counters cascade as follows:
  - A seconds tick at 59 yields 0 and increments minutes.
  - Minutes at 59 roll over to 0 and increment hours.
  - Hours at 23 roll over to 0 and increment the day count.
  - The day count wraps from 65535 to 0.
- R4: A field written with a value at or above its last legal value (seconds or minutes above 59, hours above 23) goes to 0 and carries on its next increment.
- R5: Writing the seconds (address 0), minutes (1), hours (2) or days (3) register loads that field and clears the prescaler. A `sub_tick` in the same cycle is discarded, and the next second needs a full 2^PRE_W pulses.
- R6: Control register address 6 holds the periodic select in bits [1:0]:
  - 0 disables the periodic interrupt.
  - 1 sets flag bit 0 on every seconds tick.
  - 2 sets it when minutes increment.
  - 3 sets it when the day count increments.
- R7: With alarm enable (control bit 2) set, flag bit 1 is set one cycle after the minutes increment, provided the new hour and minute equal the alarm hour (address 5) and alarm minute (address 4). Writing a matching time and further seconds ticks within that minute do not set it.
- R8: The flag register (address 7, bit 0 periodic, bit 1 alarm) is sticky. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and a set in the same cycle wins over a clear.
- R9: `irq_periodic` follows flag bit 0 and `irq_alarm` follows flag bit 1.
- R10: A read returns data on `rdata` one cycle after `rd_en`. Reading address 0 captures minutes, hours and days. Reads of addresses 1 to 3 return that captured copy, not the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sub_tick | input | 1 | One-cycle strobe at the 32.768 kHz sub-clock rate |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data, valid one cycle after `rd_en` |
| irq_periodic | output | 1 | Periodic interrupt, level, from flag bit 0 |
| irq_alarm | output | 1 | Alarm interrupt, level, from flag bit 1 |

## Verification
The counting chain is tried from several loaded start points:
- Mid-minute values show the plain prescaler ratio.
- 59 s, 59 min and 23 h loads tell a single-field rollover apart from a full cascade into the day count.
- A day load of 65535 exposes a missing wrap.
- Out-of-range loads distinguish a ">=" rollover from an "==" rollover.

The interrupt logic is driven with each periodic select against minute and day boundaries, so a wrong event source shows up as a flag at the wrong boundary. The alarm is checked against three patterns that a naive comparator would confuse: entering the match, writing the match directly, and sitting in it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;

  typedef enum logic [ADDR_W-1:0] {
    REG_SEC     = 3'd0,
    REG_MIN     = 3'd1,
    REG_HOUR    = 3'd2,
    REG_DAY     = 3'd3,
    REG_ALM_MIN = 3'd4,
    REG_ALM_HR  = 3'd5,
    REG_CTRL    = 3'd6,
    REG_FLAGS   = 3'd7
  } rtc_reg_e;

  typedef enum logic [1:0] {
    PER_OFF = 2'd0,
    PER_SEC = 2'd1,
    PER_MIN = 2'd2,
    PER_DAY = 2'd3
  } per_sel_e;

  localparam int FLAG_PER = 0;
  localparam int FLAG_ALM = 1;
  localparam int N_FLAGS  = 2;

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRE_W = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic sub_tick,
  input  logic clear,
  output logic sec_tick
);

  localparam logic [PRE_W-1:0] PRE_LAST = '1;

  logic [PRE_W-1:0] pre_q;

  assign sec_tick = sub_tick && !clear && (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pre_q <= '0;
    end else if (sub_tick) begin
      pre_q <= pre_q + 1'b1;
    end
  end

  // R2
  pre_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sub_tick && !clear) |=> $stable(pre_q));

  // R5
  pre_restart_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (pre_q == '0));

endmodule

// File: rtl/rtc_field.sv
module rtc_field #(
  parameter int W    = 6,
  parameter int LAST = 59
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt,
  output logic         carry
);

  localparam logic [W-1:0] LAST_V = W'(LAST);

  logic [W-1:0] cnt_q;

  assign cnt   = cnt_q;
  assign carry = inc && (cnt_q >= LAST_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (ld) begin
      cnt_q <= ld_val;
    end else if (inc) begin
      cnt_q <= carry ? '0 : cnt_q + 1'b1;
    end
  end

  // R3
  field_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && cnt_q >= LAST_V) |=> (cnt_q == '0));

  // R5
  field_load_chk: assert property (@(posedge clk) disable iff (rst)
    ld |=> (cnt_q == $past(ld_val)));

endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);

  logic [N-1:0] flag_q;

  assign flags = flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[i] <= 1'b0;
      end else if (set[i]) begin
        flag_q[i] <= 1'b1;
      end else if (clr[i]) begin
        flag_q[i] <= 1'b0;
      end
    end

    // R8
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> flag_q[i]);

    // R8
    flag_w1c_chk: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !set[i]) |=> !flag_q[i]);

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (flag_q[i] && !clr[i]) |=> flag_q[i]);
  end

endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top
  import rtc_pkg::*;
#(
  parameter int PRE_W = 15,
  parameter int SEC_W = 6,
  parameter int HR_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sub_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_periodic,
  output logic              irq_alarm
);

  localparam int DAY_W = DATA_W;

  rtc_reg_e reg_sel;
  assign reg_sel = rtc_reg_e'(addr);

  // write decode
  logic wr_sec, wr_min, wr_hr, wr_day, wr_time;
  assign wr_sec  = wr_en && (reg_sel == REG_SEC);
  assign wr_min  = wr_en && (reg_sel == REG_MIN);
  assign wr_hr   = wr_en && (reg_sel == REG_HOUR);
  assign wr_day  = wr_en && (reg_sel == REG_DAY);
  assign wr_time = wr_sec || wr_min || wr_hr || wr_day;

  // time chain
  logic             sec_tick;
  logic [SEC_W-1:0] sec_q, min_q;
  logic [HR_W-1:0]  hr_q;
  logic [DAY_W-1:0] day_q;
  logic             sec_c, min_c, hr_c;

  rtc_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .sub_tick (sub_tick),
    .clear    (wr_time),
    .sec_tick (sec_tick)
  );

  rtc_field #(.W(SEC_W), .LAST(59)) u_sec (
    .clk    (clk),
    .rst    (rst),
    .inc    (sec_tick),
    .ld     (wr_sec),
    .ld_val (wdata[SEC_W-1:0]),
    .cnt    (sec_q),
    .carry  (sec_c)
  );

  rtc_field #(.W(SEC_W), .LAST(59)) u_min (
    .clk    (clk),
    .rst    (rst),
    .inc    (sec_c),
    .ld     (wr_min),
    .ld_val (wdata[SEC_W-1:0]),
    .cnt    (min_q),
    .carry  (min_c)
  );

  rtc_field #(.W(HR_W), .LAST(23)) u_hr (
    .clk    (clk),
    .rst    (rst),
    .inc    (min_c),
    .ld     (wr_hr),
    .ld_val (wdata[HR_W-1:0]),
    .cnt    (hr_q),
    .carry  (hr_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      day_q <= '0;
    end else if (wr_day) begin
      day_q <= wdata[DAY_W-1:0];
    end else if (hr_c) begin
      day_q <= day_q + 1'b1;
    end
  end

  // configuration registers
  logic [SEC_W-1:0] alm_min_q;
  logic [HR_W-1:0]  alm_hr_q;
  per_sel_e         per_sel_q;
  logic             alm_en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      alm_min_q <= '0;
      alm_hr_q  <= '0;
      per_sel_q <= PER_OFF;
      alm_en_q  <= 1'b0;
    end else if (wr_en) begin
      case (reg_sel)
        REG_ALM_MIN: alm_min_q <= wdata[SEC_W-1:0];
        REG_ALM_HR:  alm_hr_q  <= wdata[HR_W-1:0];
        REG_CTRL: begin
          per_sel_q <= per_sel_e'(wdata[1:0]);
          alm_en_q  <= wdata[2];
        end
        default: ;
      endcase
    end
  end

  // interrupt events
  logic min_step_q;
  always_ff @(posedge clk) begin
    if (rst) min_step_q <= 1'b0;
    else     min_step_q <= sec_c;
  end

  logic alm_hit;
  assign alm_hit = min_step_q && alm_en_q &&
                   (min_q == alm_min_q) && (hr_q == alm_hr_q);

  logic per_hit;
  always_comb begin
    case (per_sel_q)
      PER_SEC: per_hit = sec_tick;
      PER_MIN: per_hit = sec_c;
      PER_DAY: per_hit = hr_c;
      default: per_hit = 1'b0;
    endcase
  end

  logic [N_FLAGS-1:0] flag_set, flag_clr, flags;
  always_comb begin
    flag_set           = '0;
    flag_set[FLAG_PER] = per_hit;
    flag_set[FLAG_ALM] = alm_hit;
    flag_clr           = (wr_en && reg_sel == REG_FLAGS) ? wdata[N_FLAGS-1:0] : '0;
  end

  rtc_irq_flags #(.N(N_FLAGS)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .set   (flag_set),
    .clr   (flag_clr),
    .flags (flags)
  );

  assign irq_periodic = flags[FLAG_PER];
  assign irq_alarm    = flags[FLAG_ALM];

  // coherent read snapshot
  logic [SEC_W-1:0] snap_min_q;
  logic [HR_W-1:0]  snap_hr_q;
  logic [DAY_W-1:0] snap_day_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_min_q <= '0;
      snap_hr_q  <= '0;
      snap_day_q <= '0;
    end else if (rd_en && reg_sel == REG_SEC) begin
      snap_min_q <= min_q;
      snap_hr_q  <= hr_q;
      snap_day_q <= day_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      case (reg_sel)
        REG_SEC:     rdata_q <= DATA_W'(sec_q);
        REG_MIN:     rdata_q <= DATA_W'(snap_min_q);
        REG_HOUR:    rdata_q <= DATA_W'(snap_hr_q);
        REG_DAY:     rdata_q <= DATA_W'(snap_day_q);
        REG_ALM_MIN: rdata_q <= DATA_W'(alm_min_q);
        REG_ALM_HR:  rdata_q <= DATA_W'(alm_hr_q);
        REG_CTRL:    rdata_q <= DATA_W'({alm_en_q, per_sel_q});
        default:     rdata_q <= DATA_W'(flags);
      endcase
    end
  end

  assign rdata = rdata_q;

  // R5
  no_tick_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_time |=> !sec_tick);

  // R3
  day_step_chk: assert property (@(posedge clk) disable iff (rst)
    (hr_c && !wr_day) |=> (day_q == $past(day_q) + 1'b1));

  // R6
  per_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_periodic) |-> ($past(per_sel_q) != PER_OFF));

  // R7
  alm_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_alarm) |-> $past(alm_en_q));

  // R7
  alm_on_step_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_alarm) |-> $past(min_step_q));

endmodule

// File: tb/test_rtc_alarm_top.sv
module test_rtc_alarm_top;
  import rtc_pkg::*;

  localparam int PRE_W = 2;
  localparam int SUBS  = 1 << PRE_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sub_tick = 1'b0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              irq_periodic, irq_alarm;

  int nvec = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rtc_alarm_top #(.PRE_W(PRE_W)) i_rtc_alarm_top (
    .clk          (clk),
    .rst          (rst),
    .sub_tick     (sub_tick),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .wdata        (wdata),
    .rdata        (rdata),
    .irq_periodic (irq_periodic),
    .irq_alarm    (irq_alarm)
  );

  task automatic check(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d, input bit with_sub = 1'b0);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = DATA_W'(d); sub_tick = with_sub;
    @(negedge clk);
    wr_en = 1'b0; sub_tick = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    rd_en = 1'b1; addr = ADDR_W'(a);
    @(negedge clk);
    rd_en = 1'b0;
    v = int'(rdata);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sub_tick = 1'b1;
    end
    @(negedge clk);
    sub_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_time(input int h, input int m, input int s);
    wr(REG_HOUR, h);
    wr(REG_MIN, m);
    wr(REG_SEC, s);
  endtask

  task automatic expect_time(input string req, input int h, input int m, input int s);
    int v;
    rd(REG_SEC, v);  check(req, v, s);
    rd(REG_MIN, v);  check(req, v, m);
    rd(REG_HOUR, v); check(req, v, h);
  endtask

  task automatic t_reset();
    int v;
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      check("R1 register reset", v, 0);
    end
    check("R1 irq_periodic reset", int'(irq_periodic), 0);
    check("R1 irq_alarm reset", int'(irq_alarm), 0);
  endtask

  task automatic t_prescale();
    int v;
    pulse(SUBS - 1);
    rd(REG_SEC, v); check("R2 before full second", v, 0);
    idle(6);
    rd(REG_SEC, v); check("R2 idle cycles ignored", v, 0);
    pulse(1);
    rd(REG_SEC, v); check("R2 first second", v, 1);
    pulse(2 * SUBS);
    rd(REG_SEC, v); check("R2 two more seconds", v, 3);
  endtask

  task automatic t_write_restart();
    int v;
    pulse(2);
    wr(REG_SEC, 10, 1'b1);
    pulse(SUBS - 1);
    rd(REG_SEC, v); check("R5 prescaler cleared by write", v, 10);
    pulse(1);
    rd(REG_SEC, v); check("R5 full second after write", v, 11);
  endtask

  task automatic t_cascade();
    int v;
    wr(REG_DAY, 0);
    set_time(0, 59, 59);
    pulse(SUBS);
    expect_time("R3 minute into hour", 1, 0, 0);
    set_time(23, 59, 59);
    pulse(SUBS);
    expect_time("R3 day rollover time", 0, 0, 0);
    rd(REG_DAY, v); check("R3 day increments", v, 1);
    wr(REG_DAY, 65535);
    set_time(23, 59, 59);
    pulse(SUBS);
    rd(REG_SEC, v); rd(REG_DAY, v); check("R3 day wraps", v, 0);
  endtask

  task automatic t_out_of_range();
    int v;
    set_time(2, 5, 0);
    wr(REG_SEC, 62);
    rd(REG_SEC, v); check("R4 loaded 62", v, 62);
    pulse(SUBS);
    expect_time("R4 seconds above 59 wrap", 2, 6, 0);
    set_time(30, 59, 59);
    pulse(SUBS);
    expect_time("R4 hours above 23 wrap", 0, 0, 0);
  endtask

  task automatic t_periodic();
    int v;
    wr(REG_CTRL, 1); wr(REG_FLAGS, 3);
    pulse(SUBS);
    rd(REG_FLAGS, v); check("R6 per-second flag", v, 1);
    check("R9 irq_periodic high", int'(irq_periodic), 1);
    wr(REG_FLAGS, 1);
    check("R9 irq_periodic cleared", int'(irq_periodic), 0);
    wr(REG_CTRL, 2);
    set_time(4, 0, 58); wr(REG_FLAGS, 3);
    pulse(SUBS);
    rd(REG_FLAGS, v); check("R6 per-minute quiet at 59", v, 0);
    pulse(SUBS);
    rd(REG_FLAGS, v); check("R6 per-minute on rollover", v, 1);
    wr(REG_CTRL, 3);
    set_time(5, 59, 59); wr(REG_FLAGS, 3);
    pulse(SUBS);
    rd(REG_FLAGS, v); check("R6 per-day quiet at hour", v, 0);
    set_time(23, 59, 59);
    pulse(SUBS);
    rd(REG_FLAGS, v); check("R6 per-day on day step", v, 1);
    wr(REG_CTRL, 0); wr(REG_FLAGS, 3);
    set_time(23, 59, 59);
    pulse(2 * SUBS);
    rd(REG_FLAGS, v); check("R6 select off", v, 0);
  endtask

  task automatic t_alarm();
    int v;
    wr(REG_ALM_MIN, 30); wr(REG_ALM_HR, 1); wr(REG_CTRL, 4);
    wr(REG_FLAGS, 3);
    set_time(1, 30, 0);
    idle(3);
    rd(REG_FLAGS, v); check("R7 writing match does not fire", v, 0);
    set_time(1, 29, 59);
    pulse(SUBS);
    rd(REG_FLAGS, v); check("R7 alarm on entering match", v, 2);
    check("R9 irq_alarm high", int'(irq_alarm), 1);
    wr(REG_FLAGS, 2);
    pulse(SUBS);
    rd(REG_FLAGS, v); check("R7 no refire inside minute", v, 0);
    wr(REG_CTRL, 0);
    set_time(1, 29, 59);
    pulse(SUBS);
    rd(REG_FLAGS, v); check("R7 disabled alarm quiet", v, 0);
  endtask

  task automatic t_w1c();
    int v;
    wr(REG_CTRL, 5);
    set_time(1, 29, 59); wr(REG_FLAGS, 3);
    pulse(SUBS);
    rd(REG_FLAGS, v); check("R8 both flags set", v, 3);
    wr(REG_FLAGS, 1);
    rd(REG_FLAGS, v); check("R8 clear bit 0 only", v, 2);
    wr(REG_FLAGS, 0);
    rd(REG_FLAGS, v); check("R8 writing 0 keeps flag", v, 2);
    wr(REG_FLAGS, 2);
    rd(REG_FLAGS, v); check("R8 clear bit 1", v, 0);
    wr(REG_CTRL, 0);
  endtask

  task automatic t_snapshot();
    int v;
    set_time(3, 4, 5);
    rd(REG_SEC, v); check("R10 seconds read", v, 5);
    wr(REG_MIN, 9);
    rd(REG_MIN, v); check("R10 minutes from snapshot", v, 4);
    rd(REG_SEC, v);
    rd(REG_MIN, v); check("R10 snapshot refreshed", v, 9);
    rd(REG_HOUR, v); check("R10 hours from snapshot", v, 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_prescale();
    t_write_restart();
    t_cascade();
    t_out_of_range();
    t_periodic();
    t_alarm();
    t_w1c();
    t_snapshot();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule